// File: doc/BRIEF.md
# Upper-Half Parity and Width Handshake Controller

This block looks after the upper 32-bit half of a 64-bit parallel bus on the downstream side of a bridge. When the bridge puts values on the upper address/data and byte-enable lanes, the block creates the matching even parity bit and drives it one clock later. When the bridge receives on those lanes, the block recomputes parity and compares it with the parity bit the bus shows one clock later. A mismatch raises a one-clock error pulse.

The block also decides at reset whether the upper half is in use. It reads the active-low wide-request line while reset is held, and keeps that decision until the next reset. If the wide path is absent, the block parks the upper lanes and their parity bit at fixed driven levels. It also suppresses every wide handshake.

The block drives two active-low handshake lines: the initiator's wide request and the target's wide acknowledge. Each is asserted one clock after its internal request, and each is released by driving it high for one clock before its output enable is turned off. The acknowledge is only driven while the bus shows the wide request asserted.

Top module: `bus64_ext_ctrl`

## Requirements
- R1: `par64_out` equals the XOR of all 36 bits of `ad_hi_out` and `cbe_hi_out` sampled at the previous rising clock edge, so that the 37 bits together hold an even number of ones.
- R2: `par64_oe` equals `ad_hi_oe` from one clock earlier. The parity bit therefore starts one clock after the lanes are driven and stops one clock after they are released.
- R3: If `req64_n_in` is 1 while `rst_n` is low, the block is in narrow mode. In narrow mode, `ad_hi_out` and `cbe_hi_out` are all zero with `ad_hi_oe` = 1 whatever `drv_en` and `drv_ad` are. From the first clock after reset, `par64_out` = 0 with `par64_oe` = 1.
- R4: The width decision is the value of `req64_n_in` at the last clock before `rst_n` rises. Later changes of `req64_n_in` have no effect on it. In wide mode, `ad_hi_oe` follows `drv_en` and the lanes follow `drv_ad` and `drv_cbe`.
- R5: In wide mode, one clock after `req_want` is 1, the block drives `req64_n_out` = 0 with `req64_oe` = 1.
- R6: One clock after a handshake's want input falls, that line is driven at 1 with its enable at 1 for exactly one clock. On the next clock the enable is 0, unless the want input is 1 again.
- R7: `ack64_n_out` is driven low (with `ack64_oe` = 1) one clock after a cycle in which `ack_want` = 1 and `req64_n_in` = 0 in wide mode. If `req64_n_in` = 1 in that cycle, `ack64_oe` stays 0.
- R8: An address-phase receive is one with `rx_valid` = 1 and `rx_addr_phase` = 1 while `req64_n_in` = 0 in wide mode. For such a receive, `perr` is 1 two clocks later if `par64_in` in the following cycle does not equal the XOR of `ad_hi_in` and `cbe_hi_in`. The pulse lasts one clock, and a match gives 0.
- R9: A data-phase receive (`rx_addr_phase` = 0) is only checked when both `req64_n_in` and `ack64_n_in` are 0. With `ack64_n_in` = 1, a parity mismatch leaves `perr` at 0.
- R10: While `rst_n` is low, `ad_hi_oe`, `par64_oe`, `req64_oe`, `ack64_oe` and `perr` are all 0.
- R11: In narrow mode, `req_want` and `ack_want` never enable a handshake driver, and no receive is checked, so `perr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req64_n_in | input | 1 | Wide-request line as seen on the bus; also the width strap during reset |
| ack64_n_in | input | 1 | Wide-acknowledge line as seen on the bus |
| drv_en | input | 1 | Bridge wants to drive the upper lanes this cycle |
| drv_ad | input | 32 | Upper address/data value the bridge wants to drive |
| drv_cbe | input | 4 | Upper byte-enable value the bridge wants to drive |
| ad_hi_out | output | 32 | Upper address/data drive value |
| cbe_hi_out | output | 4 | Upper byte-enable drive value |
| ad_hi_oe | output | 1 | Output enable for upper lanes |
| par64_out | output | 1 | Upper parity drive value |
| par64_oe | output | 1 | Upper parity output enable |
| ad_hi_in | input | 32 | Upper address/data as seen on the bus |
| cbe_hi_in | input | 4 | Upper byte enables as seen on the bus |
| par64_in | input | 1 | Upper parity bit as seen on the bus |
| rx_valid | input | 1 | Bridge is receiving an address or data phase this cycle |
| rx_addr_phase | input | 1 | The received phase is an address phase |
| perr | output | 1 | One-clock parity error pulse |
| req_want | input | 1 | Initiator logic asks for the wide request (frame-aligned) |
| ack_want | input | 1 | Target logic asks for the wide acknowledge (device-select aligned) |
| req64_n_out | output | 1 | Wide-request drive value, active low |
| req64_oe | output | 1 | Wide-request output enable |
| ack64_n_out | output | 1 | Wide-acknowledge drive value, active low |
| ack64_oe | output | 1 | Wide-acknowledge output enable |

## Verification
Generated parity is checked with lane values of odd, even and mixed bit counts, including all ones. These patterns separate a correct 36-bit XOR from one that leaves out the byte enables or inverts the result. The receive checker is tried with a matching parity, a wrong parity in an address phase, and a wrong parity in a data phase with and without the acknowledge. This shows whether the phase qualification and the two-clock delay are right. Both strap values are applied across separate resets, and the request line is then moved after reset. This separates a latched width decision from one that follows the live line. Handshake wants are raised, held and dropped, with and without the request seen on the bus, to expose a missing release clock or an acknowledge that is not gated.

// File: rtl/bus64_ext_pkg.sv
package bus64_ext_pkg;
  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_DRIVE   = 2'd1,
    HS_RELEASE = 2'd2
  } hs_state_e;

  localparam int unsigned HS_COUNT = 2;
  localparam int unsigned HS_REQ   = 0;
  localparam int unsigned HS_ACK   = 1;
endpackage

// File: rtl/bus64_parity_gen.sv
module bus64_parity_gen #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  lanes_ad,
  input  logic [CBE_W-1:0] lanes_cbe,
  input  logic             lanes_oe,
  output logic             par_q,
  output logic             par_oe_q
);
  logic par_d;

  always_comb begin
    par_d = ^{lanes_ad, lanes_cbe};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q    <= 1'b0;
      par_oe_q <= 1'b0;
    end else begin
      par_q    <= par_d;
      par_oe_q <= lanes_oe;
    end
  end

  assert_oe_trails_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (par_oe_q == $past(lanes_oe)));
endmodule

// File: rtl/bus64_parity_chk.sv
module bus64_parity_chk #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic [AD_W-1:0]  rx_ad,
  input  logic [CBE_W-1:0] rx_cbe,
  input  logic             rx_par,
  output logic             perr_q
);
  logic en_q;
  logic calc_q;
  logic calc_d;
  logic perr_d;

  always_comb begin
    calc_d = ^{rx_ad, rx_cbe};
    perr_d = en_q & (calc_q ^ rx_par);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      calc_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      en_q   <= chk_en;
      calc_q <= calc_d;
      perr_q <= perr_d;
    end
  end

  assert_perr_has_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && perr_q) |-> $past(en_q));
endmodule

// File: rtl/bus64_handshake.sv
module bus64_handshake
  import bus64_ext_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  output logic line_n,
  output logic line_oe
);
  hs_state_e state_q;
  hs_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (want) begin
      state_d = HS_DRIVE;
    end else if (state_q == HS_DRIVE) begin
      state_d = HS_RELEASE;
    end else begin
      state_d = HS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    line_oe = (state_q != HS_IDLE);
    line_n  = (state_q != HS_DRIVE);
  end

  assert_release_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && line_n) |=> (!line_oe || !line_n));
endmodule

// File: rtl/bus64_ext_ctrl.sv
module bus64_ext_ctrl
  import bus64_ext_pkg::*;
#(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req64_n_in,
  input  logic             ack64_n_in,
  input  logic             drv_en,
  input  logic [AD_W-1:0]  drv_ad,
  input  logic [CBE_W-1:0] drv_cbe,
  output logic [AD_W-1:0]  ad_hi_out,
  output logic [CBE_W-1:0] cbe_hi_out,
  output logic             ad_hi_oe,
  output logic             par64_out,
  output logic             par64_oe,
  input  logic [AD_W-1:0]  ad_hi_in,
  input  logic [CBE_W-1:0] cbe_hi_in,
  input  logic             par64_in,
  input  logic             rx_valid,
  input  logic             rx_addr_phase,
  output logic             perr,
  input  logic             req_want,
  input  logic             ack_want,
  output logic             req64_n_out,
  output logic             req64_oe,
  output logic             ack64_n_out,
  output logic             ack64_oe
);
  // Width strap: loaded every clock while reset is held, frozen afterwards.
  logic wide_q;
  logic strap_ce;
  logic chk_en;
  logic [HS_COUNT-1:0] hs_want;
  logic [HS_COUNT-1:0] hs_n;
  logic [HS_COUNT-1:0] hs_oe;

  always_comb begin
    strap_ce = !rst_n;
  end

  always_ff @(posedge clk) begin
    if (strap_ce) begin
      wide_q <= !req64_n_in;
    end
  end

  // Lane drive: pass through in wide mode, park at zero otherwise.
  always_comb begin
    if (wide_q) begin
      ad_hi_out  = drv_ad;
      cbe_hi_out = drv_cbe;
      ad_hi_oe   = rst_n & drv_en;
    end else begin
      ad_hi_out  = '0;
      cbe_hi_out = '0;
      ad_hi_oe   = rst_n;
    end
  end

  bus64_parity_gen #(.AD_W(AD_W), .CBE_W(CBE_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .lanes_ad (ad_hi_out),
    .lanes_cbe(cbe_hi_out),
    .lanes_oe (ad_hi_oe),
    .par_q    (par64_out),
    .par_oe_q (par64_oe)
  );

  // Receive qualification: address phases need the request, data phases both.
  always_comb begin
    chk_en = wide_q & rx_valid & !req64_n_in & (rx_addr_phase | !ack64_n_in);
  end

  bus64_parity_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .chk_en(chk_en),
    .rx_ad (ad_hi_in),
    .rx_cbe(cbe_hi_in),
    .rx_par(par64_in),
    .perr_q(perr)
  );

  always_comb begin
    hs_want[HS_REQ] = wide_q & req_want;
    hs_want[HS_ACK] = wide_q & ack_want & !req64_n_in;
  end

  for (genvar g = 0; g < HS_COUNT; g++) begin : g_hs
    bus64_handshake u_hs (
      .clk    (clk),
      .rst_n  (rst_n),
      .want   (hs_want[g]),
      .line_n (hs_n[g]),
      .line_oe(hs_oe[g])
    );
  end

  always_comb begin
    req64_n_out = hs_n[HS_REQ];
    req64_oe    = hs_oe[HS_REQ];
    ack64_n_out = hs_n[HS_ACK];
    ack64_oe    = hs_oe[HS_ACK];
  end

  assert_strap_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(wide_q));

  assert_narrow_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> (ad_hi_oe && (ad_hi_out == '0) && (cbe_hi_out == '0)));

  assert_ack_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ack64_oe && !ack64_n_out) |-> !$past(req64_n_in));

  assert_narrow_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> (!req64_oe && !ack64_oe && !perr));
endmodule

// File: tb/test_bus64_ext_ctrl.sv
`timescale 1ns/1ps
module test_bus64_ext_ctrl;
  localparam int AD_W  = 32;
  localparam int CBE_W = 4;

  localparam int K_PAR    = 0;
  localparam int K_PAROE  = 1;
  localparam int K_REQN   = 2;
  localparam int K_REQOE  = 3;
  localparam int K_ACKN   = 4;
  localparam int K_ACKOE  = 5;
  localparam int K_PERR   = 6;
  localparam int K_LANEOE = 7;
  localparam int K_LANEAD = 8;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req64_n_in, ack64_n_in, drv_en;
  logic [AD_W-1:0] drv_ad, ad_hi_out, ad_hi_in;
  logic [CBE_W-1:0] drv_cbe, cbe_hi_out, cbe_hi_in;
  logic ad_hi_oe, par64_out, par64_oe, par64_in, rx_valid, rx_addr_phase, perr;
  logic req_want, ack_want, req64_n_out, req64_oe, ack64_n_out, ack64_oe;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  sb_item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus64_ext_ctrl #(.AD_W(AD_W), .CBE_W(CBE_W)) i_bus64_ext_ctrl (
    .clk(clk), .rst_n(rst_n), .req64_n_in(req64_n_in), .ack64_n_in(ack64_n_in),
    .drv_en(drv_en), .drv_ad(drv_ad), .drv_cbe(drv_cbe),
    .ad_hi_out(ad_hi_out), .cbe_hi_out(cbe_hi_out), .ad_hi_oe(ad_hi_oe),
    .par64_out(par64_out), .par64_oe(par64_oe),
    .ad_hi_in(ad_hi_in), .cbe_hi_in(cbe_hi_in), .par64_in(par64_in),
    .rx_valid(rx_valid), .rx_addr_phase(rx_addr_phase), .perr(perr),
    .req_want(req_want), .ack_want(ack_want),
    .req64_n_out(req64_n_out), .req64_oe(req64_oe),
    .ack64_n_out(ack64_n_out), .ack64_oe(ack64_oe)
  );

  function automatic logic even_par(logic [31:0] a, logic [3:0] c);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += a[i];
    for (int i = 0; i < 4; i++) ones += c[i];
    return logic'(ones % 2);
  endfunction

  function automatic logic [31:0] actual(int kind);
    case (kind)
      K_PAR:    return {31'd0, par64_out};
      K_PAROE:  return {31'd0, par64_oe};
      K_REQN:   return {31'd0, req64_n_out};
      K_REQOE:  return {31'd0, req64_oe};
      K_ACKN:   return {31'd0, ack64_n_out};
      K_ACKOE:  return {31'd0, ack64_oe};
      K_PERR:   return {31'd0, perr};
      K_LANEOE: return {31'd0, ad_hi_oe};
      default:  return ad_hi_out;
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic expect_at(int delay, int kind, logic [31:0] exp, string req);
    sb_item_t it;
    it.due = cyc + delay;
    it.kind = kind;
    it.exp = exp;
    it.req = req;
    sb.push_back(it);
  endtask

  // Monitor: compares due scoreboard items at each falling edge.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        check(sb[i].req, $sformatf("kind%0d", sb[i].kind), actual(sb[i].kind), sb[i].exp);
        sb.delete(i);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    drv_en = 0; drv_ad = '0; drv_cbe = '0;
    ad_hi_in = '0; cbe_hi_in = '0; par64_in = 0;
    rx_valid = 0; rx_addr_phase = 0; ack64_n_in = 1;
    req_want = 0; ack_want = 0;
  endtask

  task automatic do_reset(logic strap);
    idle_inputs();
    rst_n = 0;
    req64_n_in = strap;
    repeat (3) step();
    check("R10", "lane oe in reset", {31'd0, ad_hi_oe}, 0);
    check("R10", "par oe in reset", {31'd0, par64_oe}, 0);
    check("R10", "req oe in reset", {31'd0, req64_oe}, 0);
    check("R10", "ack oe in reset", {31'd0, ack64_oe}, 0);
    check("R10", "perr in reset", {31'd0, perr}, 0);
    rst_n = 1;
    step();
  endtask

  task automatic drive_lanes(logic [31:0] a, logic [3:0] c);
    drv_en = 1; drv_ad = a; drv_cbe = c;
    expect_at(1, K_PAR, {31'd0, even_par(a, c)}, "R1");
    expect_at(1, K_PAROE, 1, "R2");
    step();
  endtask

  task automatic rx_phase(logic [31:0] a, logic [3:0] c, logic addr, logic ack_n,
                          logic par, logic exp_err, string req);
    rx_valid = 1; rx_addr_phase = addr; ack64_n_in = ack_n;
    ad_hi_in = a; cbe_hi_in = c;
    step();
    rx_valid = 0; ad_hi_in = '0; cbe_hi_in = '0; ack64_n_in = 1;
    par64_in = par;
    expect_at(1, K_PERR, {31'd0, exp_err}, req);
    expect_at(2, K_PERR, 0, req);
    step();
    par64_in = 0;
    step();
  endtask

  initial begin
    rst_n = 0;
    req64_n_in = 0;
    idle_inputs();
    fork
      begin
        // ---------- wide mode ----------
        do_reset(1'b0);
        drive_lanes(32'h0000_0001, 4'h0);
        drive_lanes(32'hFFFF_FFFF, 4'hF);
        drive_lanes(32'hA5A5_0000, 4'h1);
        drive_lanes(32'h0000_0000, 4'h8);
        drive_lanes(32'h1234_5678, 4'h6);
        drv_en = 0;
        expect_at(1, K_PAROE, 0, "R2");
        step();
        // R4: live line high after reset must not switch to parking
        req64_n_in = 1;
        drv_ad = 32'hDEAD_BEEF;
        expect_at(1, K_LANEOE, 0, "R4");
        step();
        drv_en = 1;
        expect_at(1, K_LANEAD, 32'hDEAD_BEEF, "R4");
        step();
        drv_en = 0;
        // R7: ack without request seen on the bus
        ack_want = 1;
        expect_at(1, K_ACKOE, 0, "R7");
        step();
        ack_want = 0;
        step();
        // R5 / R6: request raise, hold, release
        req64_n_in = 0;
        req_want = 1;
        expect_at(1, K_REQN, 0, "R5");
        expect_at(1, K_REQOE, 1, "R5");
        step();
        step();
        req_want = 0;
        expect_at(1, K_REQN, 1, "R6");
        expect_at(1, K_REQOE, 1, "R6");
        expect_at(2, K_REQOE, 0, "R6");
        step();
        // R7: ack with request seen, then release
        ack_want = 1;
        expect_at(1, K_ACKN, 0, "R7");
        expect_at(1, K_ACKOE, 1, "R7");
        step();
        ack_want = 0;
        expect_at(1, K_ACKN, 1, "R6");
        expect_at(1, K_ACKOE, 1, "R6");
        expect_at(2, K_ACKOE, 0, "R6");
        step();
        step();
        // R8: address-phase checks
        rx_phase(32'h0000_0003, 4'h0, 1, 1, 1, 1, "R8");
        rx_phase(32'h0000_0003, 4'h0, 1, 1, 0, 0, "R8");
        rx_phase(32'h8000_0000, 4'h0, 1, 1, 0, 1, "R8");
        // R9: data phase, acknowledge absent then present
        rx_phase(32'h0000_0007, 4'h0, 0, 1, 0, 0, "R9");
        rx_phase(32'h0000_0007, 4'h0, 0, 0, 0, 1, "R9");
        rx_phase(32'h0000_0000, 4'h1, 0, 0, 1, 0, "R9");
        // ---------- narrow mode ----------
        do_reset(1'b1);
        check("R3", "narrow lane oe", {31'd0, ad_hi_oe}, 1);
        check("R3", "narrow lane value", ad_hi_out, 0);
        check("R3", "narrow cbe value", {28'd0, cbe_hi_out}, 0);
        check("R3", "narrow par", {31'd0, par64_out}, 0);
        check("R3", "narrow par oe", {31'd0, par64_oe}, 1);
        drv_en = 1; drv_ad = 32'h0000_0001; drv_cbe = 4'h2;
        req64_n_in = 0;
        expect_at(1, K_LANEAD, 0, "R3");
        expect_at(1, K_PAR, 0, "R3");
        expect_at(1, K_LANEOE, 1, "R4");
        step();
        drv_en = 0;
        expect_at(1, K_LANEOE, 1, "R4");
        req_want = 1; ack_want = 1;
        expect_at(1, K_REQOE, 0, "R11");
        expect_at(1, K_ACKOE, 0, "R11");
        step();
        req_want = 0; ack_want = 0;
        rx_phase(32'h0000_0001, 4'h0, 1, 0, 0, 0, "R11");
        repeat (3) step();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_bad++;
          $display("FAIL watchdog: actual hung expected finished");
        end
      end
    join_any
    if (sb.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule